// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Access Splitter

This block connects a 16-bit requester to a memory built from two 8-bit banks. The memory is byte addressed with 20-bit addresses. Bytes at even addresses live in the even bank, which drives data bits 7:0. Bytes at odd addresses live in the odd bank, which drives bits 15:8. A word occupies two consecutive bytes. The byte at the lower address is the least significant one.

Both banks share one bank address, made from request address bits 19:1. Bit 0 never reaches a bank. It only decides which active-low bank enable is driven low. An aligned word uses both banks in one bank cycle. A word at an odd address needs two bank cycles on different bank rows:

- The first cycle reads or writes its low byte in the odd bank.
- The second cycle uses the even bank at the next bank row.

The block issues these cycles back to back, steers the write bytes onto the correct lanes, and joins the two read bytes into one result. A request is taken with a valid/ready handshake. Every access, read or write, ends with a one-cycle response pulse. A read returns its data with that pulse. The bank drives its read data during the bank cycle, and the block samples it at the clock edge that ends that cycle.

Top module: `byte_lane_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `bank_cyc` is 0, `bank_even_n` and `bank_odd_n` are both 1, and `rsp_valid` is 0.
- R2: A byte access at an even address is one bank cycle:
  - `bank_even_n`=0, `bank_odd_n`=1, `bank_addr`=addr[19:1].
  - A write places `req_wdata[7:0]` on `bank_wdata[7:0]`.
  - A read returns `{8'h00, bank_rdata[7:0]}`.
- R3: A byte access at an odd address is one bank cycle:
  - `bank_even_n`=1, `bank_odd_n`=0, `bank_addr`=addr[19:1].
  - A write places `req_wdata[7:0]` on `bank_wdata[15:8]`.
  - A read returns `{8'h00, bank_rdata[15:8]}`.
- R4: A word access at an even address is one bank cycle with both enables 0 and `bank_addr`=addr[19:1]. A write drives `bank_wdata`=`req_wdata`. A read returns `bank_rdata` unchanged.
- R5: A word access at an odd address is two consecutive bank cycles:
  - The first cycle has `bank_even_n`=1, `bank_odd_n`=0 and `bank_addr`=addr[19:1].
  - The second cycle has `bank_even_n`=0, `bank_odd_n`=1 and `bank_addr`=addr[19:1]+1, modulo 2^19. The address 0xFFFFF therefore wraps to bank row 0.
  - `bank_we` is the same in both cycles.
- R6: For a split word read, the result is built from two bytes:
  - Bits 7:0 are `bank_rdata[15:8]` sampled at the end of the first cycle.
  - Bits 15:8 are `bank_rdata[7:0]` sampled at the end of the second cycle.
- R7: For a split word write, the first cycle drives `req_wdata[7:0]` on `bank_wdata[15:8]`. The second cycle drives `req_wdata[15:8]` on `bank_wdata[7:0]`.
- R8: The handshake works as follows:
  - A request is taken at a clock edge where `req_valid` and `req_ready` are both 1.
  - `req_ready` stays 0 from the next cycle until the response cycle.
  - `rsp_valid` is 1 for one cycle, the cycle right after the last bank cycle.
  - `req_ready` is 1 again in that same cycle.
  - A single bank cycle access responds 2 cycles after acceptance, and a split access responds 3 cycles after acceptance.
- R9: Outside a bank cycle (`bank_cyc`=0) both bank enables are 1. In every bank cycle at least one enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, zero-extended for bytes, 0 for writes |
| bank_cyc | output | 1 | A bank cycle is in progress |
| bank_addr | output | 19 | Shared bank row address |
| bank_even_n | output | 1 | Active-low enable of the even bank (lane 7:0) |
| bank_odd_n | output | 1 | Active-low enable of the odd bank (lane 15:8) |
| bank_we | output | 1 | Bank cycle is a write |
| bank_wdata | output | 16 | Write lanes to the banks |
| bank_rdata | input | 16 | Read lanes from the banks, sampled at the end of a bank cycle |

## Verification
The checker enforces the pin rules on every cycle:
- Enables are idle outside bank cycles, and at least one is low inside them.
- Ready is low while a bank cycle runs.
- Two back-to-back bank cycles always step the row by one, move from the odd lane to the even lane, and keep the same direction.
- The response pulse comes only right after the last bank cycle.

Only the bench's scenarios can show the rest:
- The data path: which write byte lands on which lane, and how read bytes are joined and zero-extended.
- That the row a split access chooses is the right one for its request address, including the wrap from 0xFFFFF.

The bench shows these against a byte-level reference memory, using random and boundary addresses.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_SECOND = 2'd2
  } bls_state_t;

  typedef struct packed {
    logic even_n;
    logic odd_n;
    logic split;
  } lane_sel_t;

endpackage

// File: rtl/bls_lane_plan.sv
module bls_lane_plan #(
  parameter int LANE_W = 8
) (
  input  logic                  a0,
  input  logic                  word,
  input  logic [2*LANE_W-1:0]   wdata,
  output bls_pkg::lane_sel_t    sel,
  output logic [2*LANE_W-1:0]   wdata_first,
  output logic [2*LANE_W-1:0]   wdata_second
);
  localparam int DW = 2 * LANE_W;

  logic [LANE_W-1:0] low_byte;
  logic [LANE_W-1:0] high_byte;

  assign low_byte  = wdata[LANE_W-1:0];
  assign high_byte = wdata[DW-1:LANE_W];

  always_comb begin
    sel          = '{even_n: 1'b1, odd_n: 1'b1, split: 1'b0};
    wdata_first  = '0;
    wdata_second = '0;
    case ({word, a0})
      2'b00: begin
        sel.even_n = 1'b0;
        wdata_first[LANE_W-1:0] = low_byte;
      end
      2'b01: begin
        sel.odd_n = 1'b0;
        wdata_first[DW-1:LANE_W] = low_byte;
      end
      2'b10: begin
        sel.even_n  = 1'b0;
        sel.odd_n   = 1'b0;
        wdata_first = wdata;
      end
      default: begin
        sel.odd_n = 1'b0;
        sel.split = 1'b1;
        wdata_first[DW-1:LANE_W]   = low_byte;
        wdata_second[LANE_W-1:0]   = high_byte;
      end
    endcase
  end
endmodule

// File: rtl/bls_merge.sv
module bls_merge #(
  parameter int LANE_W = 8
) (
  input  logic                 a0,
  input  logic                 word,
  input  logic                 split,
  input  logic [LANE_W-1:0]    first_byte,
  input  logic [2*LANE_W-1:0]  rdata,
  output logic [2*LANE_W-1:0]  result
);
  localparam int DW = 2 * LANE_W;

  logic [LANE_W-1:0] even_lane;
  logic [LANE_W-1:0] odd_lane;

  assign even_lane = rdata[LANE_W-1:0];
  assign odd_lane  = rdata[DW-1:LANE_W];

  always_comb begin
    if (split) begin
      result = {even_lane, first_byte};
    end else if (word) begin
      result = rdata;
    end else if (a0) begin
      result = {{LANE_W{1'b0}}, odd_lane};
    end else begin
      result = {{LANE_W{1'b0}}, even_lane};
    end
  end
endmodule

// File: rtl/byte_lane_splitter.sv
module byte_lane_splitter #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_word,
  input  logic                 req_write,
  input  logic [2*LANE_W-1:0]  req_wdata,
  output logic                 rsp_valid,
  output logic [2*LANE_W-1:0]  rsp_rdata,
  output logic                 bank_cyc,
  output logic [ADDR_W-2:0]    bank_addr,
  output logic                 bank_even_n,
  output logic                 bank_odd_n,
  output logic                 bank_we,
  output logic [2*LANE_W-1:0]  bank_wdata,
  input  logic [2*LANE_W-1:0]  bank_rdata
);
  import bls_pkg::*;

  localparam int DW   = 2 * LANE_W;
  localparam int BA_W = ADDR_W - 1;

  bls_state_t        state;
  lane_sel_t         sel;
  logic [DW-1:0]     wd_first;
  logic [DW-1:0]     wd_second;
  logic [DW-1:0]     wd_second_q;
  logic              split_q;
  logic              word_q;
  logic              a0_q;
  logic [LANE_W-1:0] first_byte_q;
  logic [DW-1:0]     merged;
  logic [BA_W-1:0]   next_row;

  bls_lane_plan #(.LANE_W(LANE_W)) u_plan (
    .a0          (req_addr[0]),
    .word        (req_word),
    .wdata       (req_wdata),
    .sel         (sel),
    .wdata_first (wd_first),
    .wdata_second(wd_second)
  );

  bls_merge #(.LANE_W(LANE_W)) u_merge (
    .a0        (a0_q),
    .word      (word_q),
    .split     (split_q),
    .first_byte(first_byte_q),
    .rdata     (bank_rdata),
    .result    (merged)
  );

  assign next_row = bank_addr + BA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      req_ready    <= 1'b1;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      bank_cyc     <= 1'b0;
      bank_addr    <= '0;
      bank_even_n  <= 1'b1;
      bank_odd_n   <= 1'b1;
      bank_we      <= 1'b0;
      bank_wdata   <= '0;
      wd_second_q  <= '0;
      split_q      <= 1'b0;
      word_q       <= 1'b0;
      a0_q         <= 1'b0;
      first_byte_q <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready   <= 1'b0;
            bank_cyc    <= 1'b1;
            bank_addr   <= req_addr[ADDR_W-1:1];
            bank_even_n <= sel.even_n;
            bank_odd_n  <= sel.odd_n;
            bank_we     <= req_write;
            bank_wdata  <= wd_first;
            wd_second_q <= wd_second;
            split_q     <= sel.split;
            word_q      <= req_word;
            a0_q        <= req_addr[0];
            state       <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (split_q) begin
            first_byte_q <= bank_rdata[DW-1:LANE_W];
            bank_addr    <= next_row;
            bank_even_n  <= 1'b0;
            bank_odd_n   <= 1'b1;
            bank_wdata   <= wd_second_q;
            state        <= ST_SECOND;
          end else begin
            bank_cyc    <= 1'b0;
            bank_even_n <= 1'b1;
            bank_odd_n  <= 1'b1;
            req_ready   <= 1'b1;
            rsp_valid   <= 1'b1;
            rsp_rdata   <= bank_we ? '0 : merged;
            state       <= ST_IDLE;
          end
        end
        ST_SECOND: begin
          bank_cyc    <= 1'b0;
          bank_even_n <= 1'b1;
          bank_odd_n  <= 1'b1;
          req_ready   <= 1'b1;
          rsp_valid   <= 1'b1;
          rsp_rdata   <= bank_we ? '0 : merged;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bank_cyc,
  input logic [ADDR_W-2:0] bank_addr,
  input logic              bank_even_n,
  input logic              bank_odd_n,
  input logic              bank_we
);
  localparam int BA_W = ADDR_W - 1;

  AST_IDLE_ENABLES_HIGH: assert property (@(posedge clk) disable iff (rst)
    !bank_cyc |-> (bank_even_n && bank_odd_n)); // R9

  AST_CYCLE_HAS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    bank_cyc |-> !(bank_even_n && bank_odd_n)); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    bank_cyc |-> !req_ready); // R8

  AST_SPLIT_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (bank_cyc && $past(bank_cyc)) |-> (bank_addr == $past(bank_addr) + BA_W'(1))); // R5

  AST_SPLIT_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (bank_cyc && $past(bank_cyc)) |->
      (!bank_even_n && bank_odd_n && $past(bank_even_n) && !$past(bank_odd_n))); // R5

  AST_SPLIT_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bank_cyc && $past(bank_cyc)) |-> $stable(bank_we)); // R5

  AST_RSP_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(bank_cyc) && !bank_cyc && req_ready)); // R8

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
endmodule

bind byte_lane_splitter bls_checker #(.ADDR_W(ADDR_W)) u_bls_checker (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .bank_cyc   (bank_cyc),
  .bank_addr  (bank_addr),
  .bank_even_n(bank_even_n),
  .bank_odd_n (bank_odd_n),
  .bank_we    (bank_we)
);

// File: tb/byte_lane_splitter_bench.sv
module byte_lane_splitter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bank_cyc;
  logic [18:0] bank_addr;
  logic        bank_even_n;
  logic        bank_odd_n;
  logic        bank_we;
  logic [15:0] bank_wdata;
  logic [15:0] bank_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] bank_even [256];
  logic [7:0] bank_odd  [256];
  logic [7:0] ref_mem   [MEMB];

  logic [18:0] mon_ad [2];
  logic [1:0]  mon_en [2];
  logic [15:0] mon_wl [2];
  logic        mon_we [2];
  int          mon_ns;
  int          mon_lat;
  bit          mon_rdy_ok;
  bit          mon_idle_ok;
  logic [15:0] mon_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_splitter u_byte_lane_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bank_cyc(bank_cyc), .bank_addr(bank_addr), .bank_even_n(bank_even_n),
    .bank_odd_n(bank_odd_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata)
  );

  // Behavioural banks: asynchronous read, write at the edge ending a bank cycle.
  assign bank_rdata = {bank_odd_n  ? 8'hEE : bank_odd[bank_addr[7:0]],
                       bank_even_n ? 8'hEE : bank_even[bank_addr[7:0]]};

  always @(posedge clk) begin
    if (bank_cyc && bank_we) begin
      if (!bank_even_n) bank_even[bank_addr[7:0]] <= bank_wdata[7:0];
      if (!bank_odd_n)  bank_odd[bank_addr[7:0]]  <= bank_wdata[15:8];
    end
  end

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [7:0] ref_rd(logic [19:0] a);
    return ref_mem[a[8:0]];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [19:0] a, logic w, logic wr, logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mon_lat = 1; mon_ns = 0; mon_rdy_ok = 1'b1;
    while (!rsp_valid) begin
      if (bank_cyc && mon_ns < 2) begin
        mon_ad[mon_ns] = bank_addr;
        mon_en[mon_ns] = {bank_odd_n, bank_even_n};
        mon_wl[mon_ns] = bank_wdata;
        mon_we[mon_ns] = bank_we;
      end
      if (bank_cyc) mon_ns++;
      if (req_ready) mon_rdy_ok = 1'b0;
      @(negedge clk);
      mon_lat++;
    end
    mon_rd = rsp_rdata;
    mon_idle_ok = req_ready && !bank_cyc && bank_even_n && bank_odd_n;
  endtask

  task automatic access(logic [19:0] a, logic w, logic wr, logic [15:0] wd);
    logic [18:0] row0, row1;
    logic [19:0] a1;
    logic [15:0] exp_rd;
    string tag;
    bit split;
    split = w && a[0];
    tag = !w ? (a[0] ? "R3" : "R2") : (a[0] ? "R5" : "R4");
    row0 = a[19:1];
    row1 = row0 + 19'd1;
    a1 = a + 20'd1;
    if (!w) exp_rd = {8'h00, ref_rd(a)};
    else    exp_rd = {ref_rd(a1), ref_rd(a)};
    issue(a, w, wr, wd);
    chk(mon_ns == (split ? 2 : 1), tag, "bank cycle count", mon_ns, split ? 2 : 1);
    chk(mon_ad[0] == row0, tag, "first row", 32'(mon_ad[0]), 32'(row0));
    chk(mon_en[0] == (!w ? (a[0] ? 2'b01 : 2'b10) : (a[0] ? 2'b01 : 2'b00)),
        tag, "first enables {odd,even}", 32'(mon_en[0]), 32'(!w ? (a[0] ? 2'b01 : 2'b10) : (a[0] ? 2'b01 : 2'b00)));
    chk(mon_we[0] == wr, tag, "write flag", 32'(mon_we[0]), 32'(wr));
    if (split && mon_ns == 2) begin
      chk(mon_ad[1] == row1, "R5", "second row", 32'(mon_ad[1]), 32'(row1));
      chk(mon_en[1] == 2'b10, "R5", "second enables {odd,even}", 32'(mon_en[1]), 32'h2);
      chk(mon_we[1] == wr, "R5", "second write flag", 32'(mon_we[1]), 32'(wr));
    end
    chk(mon_lat == (split ? 3 : 2), "R8", "response latency", mon_lat, split ? 3 : 2);
    chk(mon_rdy_ok, "R8", "ready low while busy", 32'(mon_rdy_ok), 1);
    chk(mon_idle_ok, "R9", "idle pins in response cycle", 32'(mon_idle_ok), 1);
    if (wr) begin
      if (!w && !a[0]) chk(mon_wl[0][7:0] == wd[7:0], "R2", "even byte lane", 32'(mon_wl[0][7:0]), 32'(wd[7:0]));
      if (!w && a[0])  chk(mon_wl[0][15:8] == wd[7:0], "R3", "odd byte lane", 32'(mon_wl[0][15:8]), 32'(wd[7:0]));
      if (w && !a[0])  chk(mon_wl[0] == wd, "R4", "word lanes", 32'(mon_wl[0]), 32'(wd));
      if (split) begin
        chk(mon_wl[0][15:8] == wd[7:0], "R7", "split first lane", 32'(mon_wl[0][15:8]), 32'(wd[7:0]));
        chk(mon_wl[1][7:0] == wd[15:8], "R7", "split second lane", 32'(mon_wl[1][7:0]), 32'(wd[15:8]));
      end
      ref_mem[a[8:0]] = wd[7:0];
      if (w) ref_mem[a1[8:0]] = wd[15:8];
    end else begin
      chk(mon_rd == exp_rd, split ? "R6" : tag, "read result", 32'(mon_rd), 32'(exp_rd));
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bank_even[i] = init_byte(2 * i);
      bank_odd[i]  = init_byte(2 * i + 1);
    end
    for (int i = 0; i < MEMB; i++) ref_mem[i] = init_byte(i);
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(bank_cyc == 1'b0, "R1", "bank_cyc after reset", 32'(bank_cyc), 0);
    chk({bank_odd_n, bank_even_n} == 2'b11, "R1", "enables after reset",
        32'({bank_odd_n, bank_even_n}), 3);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);

    // Directed corner cases
    access(20'h00010, 1'b0, 1'b0, 16'h0);      // even byte read
    access(20'h00011, 1'b0, 1'b0, 16'h0);      // odd byte read
    access(20'h00020, 1'b1, 1'b0, 16'h0);      // aligned word read
    access(20'h00023, 1'b1, 1'b0, 16'h0);      // split word read
    access(20'h00040, 1'b0, 1'b1, 16'hAA5C);   // even byte write
    access(20'h00041, 1'b0, 1'b1, 16'h55C3);   // odd byte write
    access(20'h00040, 1'b1, 1'b0, 16'h0);
    access(20'h01FFF, 1'b1, 1'b1, 16'hBEEF);   // split write across row boundary
    access(20'h01FFF, 1'b1, 1'b0, 16'h0);
    access(20'h02000, 1'b0, 1'b0, 16'h0);
    access(20'hFFFFF, 1'b1, 1'b1, 16'hC0DE);   // wrap to row 0
    access(20'hFFFFF, 1'b1, 1'b0, 16'h0);
    access(20'h00000, 1'b0, 1'b0, 16'h0);
    access(20'h00002, 1'b1, 1'b1, 16'h1234);
    access(20'h00002, 1'b1, 1'b0, 16'h0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [19:0] ra;
      ra = 20'($urandom());
      if (n % 5 == 0) ra[8:1] = 8'hFF;
      access(ra, 1'($urandom()), 1'($urandom()), 16'($urandom()));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule